// File: doc/BRIEF.md
# Phase-Domain Modulator Timing Generator

This block produces all digital timing for a temperature sensor that reads the phase lag of an on-chip electrothermal filter with a phase-domain sigma-delta modulator. A single phase counter, clocked by the crystal-derived system clock, defines one heater drive period. From that counter the block makes four things. The first is the square-wave heater drive. The second is a pair of reference square waves at the same frequency, one leading and one lagging. The third is the single-bit phase DAC output, which is whichever reference the last latched comparator bit chose. The fourth is a once-per-sample strobe and a slow chopping signal.

When the chop signal is high, the heater drive and every reference waveform are inverted together. The phase relations between them stay the same, and the comparator bit picks a reference in the same way in both chop phases. Sizes are parameters. `PERIOD` is the number of clocks per drive period (default 188, about 85 kHz from a 16 MHz clock). `SAMPLE_DIV` is the number of drive periods per modulator sample (default 32, about 2.66 kHz). `CHOP_SAMPLES` is the number of samples per chop half-period (default 66, about 20 Hz). `LEAD_DEG` and `LAG_DEG` set the reference lags in degrees (defaults 45 and 135, so the two references sit 90 degrees apart around a nominal 90 degree lag).

Top module: `pdm_timing_gen`

## Requirements
- R1: Count edge n from 0 at the first rising clock edge with `rst` low, and let p = n mod `PERIOD`. After edge n, `drive_o` equals (p < `PERIOD`/2) XOR `chop_o`.
- R2: Each reference offset is round(`PERIOD`·deg/360) clocks, which gives 24 and 71 at the defaults. After edge n, `ref_lead_o` equals (((p − lead offset) mod `PERIOD`) < `PERIOD`/2) XOR `chop_o`. `ref_lag_o` follows the same rule with the lag offset.
- R3: After every edge, `fb_o` equals `ref_lead_o` when `sel_o` is 1 and `ref_lag_o` when `sel_o` is 0. A new selection takes effect on `fb_o` at the same edge where `sample_o` rises.
- R4: `sample_o` is high for exactly the cycle after each edge n with n mod (`PERIOD`·`SAMPLE_DIV`) = 0. At these edges the un-inverted drive (`drive_o` XOR `chop_o`) rises.
- R5: At a strobe edge, `sel_o` takes the value of `cmp_i`. Values of `cmp_i` at any other edge have no effect on `sel_o` or `fb_o`.
- R6: After edge n, `chop_o` equals floor(n / (`PERIOD`·`SAMPLE_DIV`·`CHOP_SAMPLES`)) mod 2. It changes only at an edge where `sample_o` rises.
- R7: While `chop_o` is 1, the drive, both references and the feedback are all inverted, and the rule in R3 for choosing a reference stays the same.
- R8: While `rst` is high, every output is 0, which means the chop phase is non-inverted and the lagging reference is selected. Edge counting restarts from 0 after `rst` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, derived from the crystal |
| rst | input | 1 | Synchronous active-high reset |
| cmp_i | input | 1 | Comparator decision from the modulator's quantizer |
| drive_o | output | 1 | Heater drive square wave, chop-inverted |
| ref_lead_o | output | 1 | Leading phase reference, chop-inverted |
| ref_lag_o | output | 1 | Lagging phase reference, chop-inverted |
| fb_o | output | 1 | Selected reference fed back to the demodulator |
| sample_o | output | 1 | One-cycle modulator sample strobe |
| chop_o | output | 1 | Low-frequency chop phase (1 = inverted) |
| sel_o | output | 1 | Latched comparator bit (1 = leading reference) |

## Verification
Every output is a single register that is loaded from the phase counter's value at edge n, so every result for edge n is due in the cycle that follows edge n, with no further delay. The bench keeps its own edge number n, drives `cmp_i` at the falling edge before edge n and samples all outputs at the falling edge after edge n. It then compares them with values computed from n alone. The bench latches a comparator value only at edges where n is a multiple of the sample period. This lets random `cmp_i` toggling between strobes show any leak into the selection or into `fb_o` at the very next sample point. A reset in the middle of the run restarts n and checks that all outputs return to 0.

// File: rtl/pdmt_pkg.sv
package pdmt_pkg;
  // Nearest-integer division for deriving clock-count offsets from degrees.
  function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
    return (num + den / 2) / den;
  endfunction
endpackage

// File: rtl/pdmt_phase_cnt.sv
module pdmt_phase_cnt #(
  parameter int unsigned PERIOD     = 188,
  parameter int unsigned SAMPLE_DIV = 32,
  localparam int unsigned CW = $clog2(PERIOD),
  localparam int unsigned PW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] phase,
  output logic          strobe_now
);
  logic [PW-1:0] per;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      per   <= '0;
    end else if (phase == CW'(PERIOD - 1)) begin
      phase <= '0;
      per   <= (per == PW'(SAMPLE_DIV - 1)) ? '0 : per + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign strobe_now = (phase == '0) && (per == '0);
endmodule

// File: rtl/pdmt_ref_gen.sv
module pdmt_ref_gen #(
  parameter int unsigned PERIOD = 188,
  parameter int unsigned NREF   = 3,
  parameter int unsigned OFS [NREF] = '{default: 0},
  localparam int unsigned CW   = $clog2(PERIOD),
  localparam int unsigned HALF = PERIOD / 2
) (
  input  logic [CW-1:0]   phase,
  output logic [NREF-1:0] lvl
);
  logic [31:0] p32;
  assign p32 = 32'(phase);

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic [31:0] shifted;
    assign shifted = (p32 >= OFS[g]) ? (p32 - OFS[g]) : (p32 + PERIOD - OFS[g]);
    assign lvl[g]  = (shifted < HALF);
  end
endmodule

// File: rtl/pdmt_chop_ctl.sv
module pdmt_chop_ctl #(
  parameter int unsigned CHOP_SAMPLES = 66,
  localparam int unsigned SW = $clog2(CHOP_SAMPLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_now,
  output logic chop_next,
  output logic chop_q
);
  logic [SW-1:0] sc;
  logic          wrap;

  assign wrap      = strobe_now && (sc == SW'(CHOP_SAMPLES));
  assign chop_next = chop_q ^ wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sc     <= '0;
      chop_q <= 1'b0;
    end else if (strobe_now) begin
      sc     <= wrap ? SW'(1) : sc + 1'b1;
      chop_q <= chop_next;
    end
  end
endmodule

// File: rtl/pdm_timing_gen.sv
module pdm_timing_gen #(
  parameter int unsigned PERIOD       = 188,
  parameter int unsigned SAMPLE_DIV   = 32,
  parameter int unsigned CHOP_SAMPLES = 66,
  parameter int unsigned LEAD_DEG     = 45,
  parameter int unsigned LAG_DEG      = 135
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_i,
  output logic drive_o,
  output logic ref_lead_o,
  output logic ref_lag_o,
  output logic fb_o,
  output logic sample_o,
  output logic chop_o,
  output logic sel_o
);
  import pdmt_pkg::*;

  localparam int unsigned CW       = $clog2(PERIOD);
  localparam int unsigned LEAD_OFS = round_div(PERIOD * LEAD_DEG, 360);
  localparam int unsigned LAG_OFS  = round_div(PERIOD * LAG_DEG, 360);
  localparam int unsigned NREF     = 3;
  localparam int unsigned OFS_TAB [NREF] = '{0, LEAD_OFS, LAG_OFS};

  logic [CW-1:0]   phase;
  logic            strobe_now;
  logic [NREF-1:0] lvl;
  logic            chop_next;
  logic            sel_next;

  pdmt_phase_cnt #(.PERIOD(PERIOD), .SAMPLE_DIV(SAMPLE_DIV)) u_cnt (
    .clk(clk), .rst(rst), .phase(phase), .strobe_now(strobe_now)
  );

  pdmt_ref_gen #(.PERIOD(PERIOD), .NREF(NREF), .OFS(OFS_TAB)) u_ref (
    .phase(phase), .lvl(lvl)
  );

  pdmt_chop_ctl #(.CHOP_SAMPLES(CHOP_SAMPLES)) u_chop (
    .clk(clk), .rst(rst), .strobe_now(strobe_now),
    .chop_next(chop_next), .chop_q(chop_o)
  );

  // The comparator bit is latched only on the strobe; 1 picks the leading reference.
  assign sel_next = strobe_now ? cmp_i : sel_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o    <= 1'b0;
      ref_lead_o <= 1'b0;
      ref_lag_o  <= 1'b0;
      fb_o       <= 1'b0;
      sample_o   <= 1'b0;
      sel_o      <= 1'b0;
    end else begin
      drive_o    <= lvl[0] ^ chop_next;
      ref_lead_o <= lvl[1] ^ chop_next;
      ref_lag_o  <= lvl[2] ^ chop_next;
      fb_o       <= (sel_next ? lvl[1] : lvl[2]) ^ chop_next;
      sample_o   <= strobe_now;
      sel_o      <= sel_next;
    end
  end
endmodule

// File: rtl/pdmt_checker.sv
module pdmt_checker (
  input logic clk,
  input logic rst,
  input logic drive_o,
  input logic ref_lead_o,
  input logic ref_lag_o,
  input logic fb_o,
  input logic sample_o,
  input logic chop_o,
  input logic sel_o
);
  logic base_drive;
  assign base_drive = drive_o ^ chop_o;

  AST_FB_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    fb_o == (sel_o ? ref_lead_o : ref_lag_o)); // R3

  AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> (base_drive && !$past(base_drive))); // R4

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !sample_o); // R4

  AST_SEL_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (sel_o != $past(sel_o)) |-> sample_o); // R5

  AST_CHOP_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (chop_o != $past(chop_o)) |-> sample_o); // R6

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> !(drive_o || ref_lead_o || ref_lag_o || fb_o || sample_o || chop_o || sel_o)); // R8
endmodule

bind pdm_timing_gen pdmt_checker u_chk (
  .clk(clk), .rst(rst), .drive_o(drive_o), .ref_lead_o(ref_lead_o),
  .ref_lag_o(ref_lag_o), .fb_o(fb_o), .sample_o(sample_o),
  .chop_o(chop_o), .sel_o(sel_o)
);

// File: tb/sim_pdm_timing_gen.sv
module sim_pdm_timing_gen;
  localparam int P    = 20;
  localparam int S    = 4;
  localparam int C    = 3;
  localparam int H    = P / 2;
  localparam int LEAD = (P * 45 + 180) / 360;   // 3
  localparam int LAG  = (P * 135 + 180) / 360;  // 8
  localparam int PS   = P * S;
  localparam int PSC  = PS * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_i = 1'b0;
  logic drive_o, ref_lead_o, ref_lag_o, fb_o, sample_o, chop_o, sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pdm_timing_gen #(.PERIOD(P), .SAMPLE_DIV(S), .CHOP_SAMPLES(C)) u0 (
    .clk(clk), .rst(rst), .cmp_i(cmp_i), .drive_o(drive_o), .ref_lead_o(ref_lead_o),
    .ref_lag_o(ref_lag_o), .fb_o(fb_o), .sample_o(sample_o), .chop_o(chop_o), .sel_o(sel_o)
  );

  function automatic logic lvl_at(int n, int ofs);
    return logic'((((n % P) + P - ofs) % P) < H);
  endfunction

  function automatic logic chop_at(int n);
    return logic'((n / PSC) % 2);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_reset();
    check("R8 drive", drive_o, 1'b0);
    check("R8 lead", ref_lead_o, 1'b0);
    check("R8 lag", ref_lag_o, 1'b0);
    check("R8 fb", fb_o, 1'b0);
    check("R8 sample", sample_o, 1'b0);
    check("R8 chop", chop_o, 1'b0);
    check("R8 sel lagging", sel_o, 1'b0);
  endtask

  // mode 0: random comparator; mode 1: toggles every cycle; mode 2: constant 1
  task automatic run(int cycles, int mode);
    logic exp_sel = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      case (mode)
        0: cmp_i = logic'($urandom & 1);
        1: cmp_i = logic'(n & 1);
        default: cmp_i = 1'b1;
      endcase
      if (n % PS == 0) exp_sel = cmp_i;
      @(posedge clk);
      @(negedge clk);
      begin
        logic c, ld, lg;
        c  = chop_at(n);
        ld = lvl_at(n, LEAD) ^ c;
        lg = lvl_at(n, LAG) ^ c;
        check("R1 drive", drive_o, lvl_at(n, 0) ^ c);
        check("R2 lead", ref_lead_o, ld);
        check("R2 lag", ref_lag_o, lg);
        check("R3 R7 fb", fb_o, exp_sel ? ld : lg);
        check("R4 sample", sample_o, logic'(n % PS == 0));
        check("R5 sel", sel_o, exp_sel);
        check("R6 chop", chop_o, c);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    run(4 * PSC + 7, 0);          // random comparator across several chop phases
    rst = 1'b1;                   // reset in mid-period
    repeat (2) @(negedge clk);
    check_reset();
    rst = 1'b0;
    run(2 * PSC + 3, 1);          // directed: comparator toggling each cycle
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;
    run(PSC + PS, 2);             // directed: leading reference held
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule